// File: doc/BRIEF.md
# Dual-Mode Row Select Decoder

This block drives the active-high row select lines of a capacitive sensor array. The rows are split into equal blocks of lines. In sensing mode the block acts as an ordinary address decoder and raises one line. In calibration mode it raises every line of one chosen block except the addressed one. Many rows can then run their calibration step together, which is safe because the pixel outputs share their data lines through a wired-OR.

A single decoder covers both modes. The address is decoded to a one-hot vector. A per-block invert control, driven by the mode and block-select inputs, then flips the decoded lines of the chosen block with exclusive-OR gates. Each block holds as many lines as there are calibration repetitions. Stepping the in-block offset across a full block therefore gives each line of that block one active step fewer than the block size. With 8 lines this is 7 steps, which covers a 3-bit trim code from 0 to 7. The select vector is registered, so the lines change only on a clock edge.

Top module: `row_sel_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every select line is 0 after that edge.
- R2: With `en`=1 and `cal_mode`=0, exactly one line is active after the next edge: line index `row_addr`. Line i is bit i of `sel_lines`, and block b owns bits b*LINES_PER_BLOCK to b*LINES_PER_BLOCK+LINES_PER_BLOCK-1.
- R3: With `en`=1 and `cal_mode`=1, every line of block `blk_sel` is active except the line at in-block offset `row_addr[2:0]`. The upper address bits (`row_addr[4:3]`) have no effect in this mode.
- R4: With `en`=1 and `cal_mode`=1, every line outside block `blk_sel` is inactive.
- R5: With `en`=0, every select line is 0 after the next edge, in either mode.
- R6: In calibration mode, stepping the offset through 0..7 with a fixed block gives each line of that block exactly 7 active cycles and every other line none.
- R7: `sel_lines` changes only at a rising clock edge. A change on the inputs between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Drive enable; 0 forces all lines inactive |
| cal_mode | input | 1 | 0 = sensing (one line), 1 = calibration (all but one in a block) |
| row_addr | input | 5 | Row address; calibration uses only the low 3 bits as the in-block offset |
| blk_sel | input | 2 | Block chosen for calibration |
| sel_lines | output | 32 | Registered active-high row select lines |

## Verification
A wrong invert control or a wrong decode would show at the ports one cycle after the inputs are applied. It would appear as a wrong line count (anything other than 1 in sensing, or 7 in calibration), or as a line lit in an unselected block. The bench compares the whole vector on every cycle against a behavioural model, so a fault in a single line is caught on the first cycle that exercises it. A register that updated early would show up as outputs that change before the edge. The bench samples just after changing the inputs to catch this.

// File: rtl/row_sel_pkg.sv
// Shared helpers for the row select decoder.
// Assumes widths of at least one bit for every field.
package row_sel_pkg;

    // Width of a field able to index n items, never less than 1
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic {
        MODE_SENSE = 1'b0,
        MODE_CAL   = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/rsd_addr_decoder.sv
// One-hot address decoder.
// Drives bit `addr` high and every other bit low; combinational.
// Assumes N_LINES <= 2**AW.
module rsd_addr_decoder #(
    parameter int N_LINES = 32,
    parameter int AW      = 5
) (
    input  logic [AW-1:0]      addr,
    output logic [N_LINES-1:0] onehot
);

    // One comparator per line
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign onehot[i] = (addr == AW'(i));
    end

endmodule

// File: rtl/rsd_block_invert.sv
// Per-block exclusive-OR inversion stage.
// When invert is enabled for a block, that block's decoded lines are flipped,
// which turns a one-hot (or all-zero) slice into all-but-one (or all-ones).
// Assumes at most one block is inverted at a time.
module rsd_block_invert #(
    parameter int NUM_BLOCKS      = 4,
    parameter int LINES_PER_BLOCK = 8,
    parameter int BW              = 2,
    localparam int N_LINES        = NUM_BLOCKS * LINES_PER_BLOCK
) (
    input  logic               cal,
    input  logic [BW-1:0]      blk,
    input  logic [N_LINES-1:0] dec_in,
    output logic [N_LINES-1:0] lines_out
);

    logic [NUM_BLOCKS-1:0] inv_ctl;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        // Invert control for this block: calibration and block chosen
        assign inv_ctl[b] = cal && (blk == BW'(b));
        // Exclusive-OR of the decoded slice with the block's control
        assign lines_out[b*LINES_PER_BLOCK +: LINES_PER_BLOCK] =
            dec_in[b*LINES_PER_BLOCK +: LINES_PER_BLOCK] ^ {LINES_PER_BLOCK{inv_ctl[b]}};
    end

endmodule

// File: rtl/row_sel_decoder.sv
// Dual-mode row select decoder (top).
// Sensing: one line at row_addr. Calibration: all lines of block blk_sel
// except the one at in-block offset row_addr[OW-1:0]; other blocks off.
// en=0 clears all lines. Output registered; synchronous active-low reset.
// Assumes LINES_PER_BLOCK and NUM_BLOCKS are powers of two.
module row_sel_decoder #(
    parameter int NUM_BLOCKS      = 4,
    parameter int LINES_PER_BLOCK = 8,
    localparam int N_LINES        = NUM_BLOCKS * LINES_PER_BLOCK,
    localparam int AW             = row_sel_pkg::idx_width(N_LINES),
    localparam int BW             = row_sel_pkg::idx_width(NUM_BLOCKS),
    localparam int OW             = row_sel_pkg::idx_width(LINES_PER_BLOCK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cal_mode,
    input  logic [AW-1:0]      row_addr,
    input  logic [BW-1:0]      blk_sel,
    output logic [N_LINES-1:0] sel_lines
);
    import row_sel_pkg::*;

    sel_mode_e          mode;
    logic [AW-1:0]      eff_addr;
    logic [N_LINES-1:0] dec_lines;
    logic [N_LINES-1:0] inv_lines;
    logic [N_LINES-1:0] sel_d;

    assign mode = sel_mode_e'(cal_mode);

    // Effective address: in calibration the block bits come from blk_sel
    always_comb begin
        if (mode == MODE_CAL) begin
            eff_addr = AW'({blk_sel, row_addr[OW-1:0]});
        end else begin
            eff_addr = row_addr;
        end
    end

    rsd_addr_decoder #(
        .N_LINES (N_LINES),
        .AW      (AW)
    ) u_dec (
        .addr    (eff_addr),
        .onehot  (dec_lines)
    );

    rsd_block_invert #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .LINES_PER_BLOCK (LINES_PER_BLOCK),
        .BW              (BW)
    ) u_inv (
        .cal       (mode == MODE_CAL),
        .blk       (blk_sel),
        .dec_in    (dec_lines),
        .lines_out (inv_lines)
    );

    // Enable gating ahead of the output register
    always_comb begin
        sel_d = en ? inv_lines : '0;
    end

    // Output register: glitch-free select lines, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lines <= '0;
        end else begin
            sel_lines <= sel_d;
        end
    end

    // R1: reset clears every line
    p_reset_clear_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (sel_lines == '0))
        else $error("p_reset_clear_r1");

    // R2: sensing mode drives exactly one line, the addressed one
    p_sense_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(cal_mode)) |->
            ($onehot(sel_lines) && sel_lines[$past(row_addr)]))
        else $error("p_sense_onehot_r2");

    // R3: calibration drives all but one line
    p_cal_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $past(cal_mode)) |->
            ($countones(sel_lines) == LINES_PER_BLOCK - 1))
        else $error("p_cal_count_r3");

    // R4: calibration never lights the chosen block's addressed line
    p_cal_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $past(cal_mode)) |->
            !sel_lines[{$past(blk_sel), $past(row_addr[OW-1:0])}])
        else $error("p_cal_hole_r4");

    // R5: disabled means dark
    p_disable_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (sel_lines == '0))
        else $error("p_disable_dark_r5");

endmodule

// File: tb/row_sel_decoder_tb_top.sv
// Bench for row_sel_decoder: behavioural cycle model, compared every clock.
module row_sel_decoder_tb_top;

    localparam int NB  = 4;
    localparam int LPB = 8;
    localparam int NL  = NB * LPB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          cal_mode;
    logic [4:0]    row_addr;
    logic [1:0]    blk_sel;
    logic [NL-1:0] sel_lines;

    int            checks   = 0;
    int            failures = 0;
    int            cyc      = 0;
    logic [NL-1:0] exp_q    = '0;
    int            act_cnt [NL];

    always #5 clk = ~clk;

    row_sel_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cal_mode  (cal_mode),
        .row_addr  (row_addr),
        .blk_sel   (blk_sel),
        .sel_lines (sel_lines)
    );

    // Behavioural next-state model from the requirements
    function automatic logic [NL-1:0] model(input logic r, input logic e,
                                            input logic c, input int a, input int b);
        logic [NL-1:0] v = '0;
        if (!r || !e) return v;
        if (!c) begin
            v[a] = 1'b1;
        end else begin
            for (int k = 0; k < LPB; k++)
                if (k != (a % LPB)) v[b*LPB + k] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [NL-1:0] got,
                         input logic [NL-1:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Apply inputs after a falling edge, model the rising edge, compare after it
    task automatic step(input logic r, input logic e, input logic c,
                        input int a, input int b);
        string tag;
        rst_n = r; en = e; cal_mode = c;
        row_addr = 5'(a); blk_sel = 2'(b);
        #1;
        check("R7 hold before edge", sel_lines, exp_q);
        @(posedge clk);
        exp_q = model(r, e, c, a, b);
        @(negedge clk);
        if (!r)       tag = "R1 reset";
        else if (!e)  tag = "R5 disabled";
        else if (!c)  tag = "R2 sensing";
        else          tag = "R3 R4 calibration";
        check(tag, sel_lines, exp_q);
        for (int k = 0; k < NL; k++) if (sel_lines[k]) act_cnt[k]++;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; cal_mode = 1'b1; row_addr = '0; blk_sel = '0;
        @(negedge clk);
        // R1: reset with active-looking inputs
        step(0, 1, 1, 3, 2);
        step(0, 1, 0, 9, 0);
        // R2: walk every address in sensing
        for (int a = 0; a < NL; a++) step(1, 1, 0, a, a % NB);
        // R3 R4: every block and offset, with varied upper address bits
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < LPB; o++)
                step(1, 1, 1, ((b + o) % NB) * LPB + o, b);
        // R5: disabled in both modes
        step(1, 0, 0, 5, 1);
        step(1, 0, 1, 5, 1);
        step(1, 1, 0, 17, 3);
        step(1, 0, 1, 2, 3);
        // R6: full calibration sweep of block 2, counting activations
        for (int k = 0; k < NL; k++) act_cnt[k] = 0;
        for (int o = 0; o < LPB; o++) step(1, 1, 1, o, 2);
        for (int k = 0; k < NL; k++) begin
            checks++;
            if (act_cnt[k] != ((k / LPB == 2) ? LPB - 1 : 0)) begin
                failures++;
                $display("FAIL R6 line %0d: got %0d expected %0d", k, act_cnt[k],
                         (k / LPB == 2) ? LPB - 1 : 0);
            end
        end
        // R1 again mid-run, then recover
        step(0, 1, 1, 1, 1);
        step(1, 1, 0, 31, 0);
        finish_run();
    end

endmodule